// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed byte-wide memory against corruption while its supply comes and goes. Three supply-level flags come from analog comparators outside the block. One says the supply is above the protect level. One says it is above the full-operation level. One says it is above the switchover level. The block passes them through synchronisers and a filter. From them it decides whether the memory's chip, write and output strobes may pass, whether the data drivers may be enabled, and whether the array is fed from the external supply or from the backup cell.

Once the supply has returned, protection is kept for a programmable number of clock cycles. That interval starts again if the supply sags below the full-operation level before it ends. A new part is shipped with its backup cell held disconnected. The cell is armed only by the first qualified power-up. From then on the arming survives the ordinary reset and is undone only by a separate factory-reset input.

Top module: `pwr_guard`

## Requirements
- R1: After factory reset, `protect` is 1, `bat_sel` is 0, all three strobe outputs are 1 and `dq_drv` is 0.
- R2: While `protect` is 1, `ce_n_o`, `we_n_o` and `oe_n_o` are 1 and `dq_drv` is 0, whatever the strobe inputs do.
- R3: While `protect` is 0, each strobe output equals its input. `dq_drv` is 1 exactly when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1 (a read).
- R4: Protection ends only after `vdd_above_norm` has been high for DEB_CYC qualifying cycles and then for a further REC_CYC cycles. From a flag rise in a protected state, `protect` falls about SYNC_STG+DEB_CYC+REC_CYC+1 clock edges later.
- R5: A fall of `vdd_above_prot` sets `protect` within SYNC_STG+2 clock edges, from any state. No filtering delays this path.
- R6: In normal operation, a fall of `vdd_above_norm` alone, with `vdd_above_prot` still high, does not set `protect`.
- R7: Until the first qualified power-up after factory reset, `bat_sel` stays 0 for every pattern of the flags.
- R8: Once armed, a fall of `vdd_above_norm` sets `bat_sel` to 1, even while `vdd_above_swap` is still high.
- R9: Once armed, `bat_sel` stays 1 while `vdd_above_swap` is low. It returns to 0 after `vdd_above_swap` rises, even while `vdd_above_norm` is still low.
- R10: A dip of `vdd_above_norm` during the recovery interval restarts the full REC_CYC count.
- R11: The ordinary reset `rst_n` does not clear the arming. After it is released with `vdd_above_swap` low, `bat_sel` returns to 1 within 3 edges.
- R12: `fact_rst_n` clears the arming. After it is released, `bat_sel` is 0 even with `vdd_above_swap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Ordinary asynchronous reset, active low; keeps the arming |
| fact_rst_n | input | 1 | Factory reset, active low; also clears the arming |
| vdd_above_prot | input | 1 | Comparator flag: supply above the protect level |
| vdd_above_norm | input | 1 | Comparator flag: supply above the full-operation level |
| vdd_above_swap | input | 1 | Comparator flag: supply above the switchover level |
| ce_n_i | input | 1 | Chip enable from the host, active low |
| we_n_i | input | 1 | Write enable from the host, active low |
| oe_n_i | input | 1 | Output enable from the host, active low |
| ce_n_o | output | 1 | Gated chip enable to the array |
| we_n_o | output | 1 | Gated write enable to the array |
| oe_n_o | output | 1 | Gated output enable to the array |
| dq_drv | output | 1 | Data driver enable; 0 means high impedance |
| protect | output | 1 | Write protection active |
| bat_sel | output | 1 | 1 feeds the array from the backup cell, 0 from the external supply |

## Verification
A wrong state appears at the ports in one of a few ways. Strobes that pass during protection, or are blocked during normal operation, show on the same cycle as the inputs change. A protection release that comes too early or too late shows as a misplaced fall of `protect`, measured against the flag rise. A state machine that misses a protect-flag fall keeps `protect` low beyond SYNC_STG+2 edges. A wrong arming bit shows only through `bat_sel`: after a supply fall, or within three edges of a reset released with the switchover flag low.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

   typedef enum logic [1:0] {
      ST_SEALED  = 2'd0,
      ST_BATTERY = 2'd1,
      ST_RECOVER = 2'd2,
      ST_NORMAL  = 2'd3
   } guard_state_t;

   localparam int FL_PROT = 0;
   localparam int FL_NORM = 1;
   localparam int FL_SWAP = 2;
   localparam int NFLAG   = 3;

endpackage

// File: rtl/pg_flag_cond.sv
module pg_flag_cond #(
   parameter int SYNC_STG = 2,
   parameter int DEB_CYC  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic good
);
   localparam int DW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;

   logic [SYNC_STG-1:0] sr;
   logic                s_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[SYNC_STG-2:0], raw};
   end
   assign s_q = sr[SYNC_STG-1];

   generate
      if (DEB_CYC == 0) begin : g_bypass
         assign good = s_q;
      end else begin : g_filter
         logic [DW-1:0] cnt;
         logic          good_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               good_q <= 1'b0;
            end else if (!s_q) begin
               cnt    <= '0;
               good_q <= 1'b0;
            end else if (!good_q) begin
               if (cnt == DW'(DEB_CYC - 1)) begin
                  good_q <= 1'b1;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
         assign good = good_q;
      end
   endgenerate
endmodule

// File: rtl/pg_rec_timer.sv
module pg_rec_timer #(
   parameter int REC_CYC = 25_000_000,
   parameter int CNT_W   = $clog2(REC_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic             done,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYC - 1);

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (run && !done)  cnt <= cnt + 1'b1;
      else                    cnt <= '0;
   end
endmodule

// File: rtl/pg_fresh_latch.sv
module pg_fresh_latch (
   input  logic clk,
   input  logic fact_rst_n,
   input  logic arm,
   output logic armed
);
   always_ff @(posedge clk or negedge fact_rst_n) begin
      if (!fact_rst_n) armed <= 1'b0;
      else if (arm)    armed <= 1'b1;
   end
endmodule

// File: rtl/pg_supply_switch.sv
module pg_supply_switch (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic norm_f,
   input  logic swap_f,
   output logic bat_sel
);
   logic norm_q, swap_q, sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         norm_q <= 1'b0;
         swap_q <= 1'b0;
         sel_q  <= 1'b0;
      end else begin
         norm_q <= norm_f;
         swap_q <= swap_f;
         if (norm_f)                 sel_q <= 1'b0;
         else if (!armed)            sel_q <= 1'b0;
         else if (!swap_f)           sel_q <= 1'b1;
         else if (norm_q)            sel_q <= 1'b1;
         else if (swap_f && !swap_q) sel_q <= 1'b0;
      end
   end
   assign bat_sel = sel_q;
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
   import pwr_guard_pkg::*;
#(
   parameter int SYNC_STG = 2,
   parameter int DEB_CYC  = 16,
   parameter int REC_CYC  = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fact_rst_n,
   input  logic vdd_above_prot,
   input  logic vdd_above_norm,
   input  logic vdd_above_swap,
   input  logic ce_n_i,
   input  logic we_n_i,
   input  logic oe_n_i,
   output logic ce_n_o,
   output logic we_n_o,
   output logic oe_n_o,
   output logic dq_drv,
   output logic protect,
   output logic bat_sel
);
   localparam int CNT_W = $clog2(REC_CYC);

   generate
      if (SYNC_STG < 2) begin : g_bad_sync
         $error("pwr_guard: SYNC_STG must be at least 2");
      end
      if (DEB_CYC < 0) begin : g_bad_deb
         $error("pwr_guard: DEB_CYC must not be negative");
      end
      if (REC_CYC < 2) begin : g_bad_rec
         $error("pwr_guard: REC_CYC must be at least 2");
      end
   endgenerate

   logic             rst_all_n;
   logic [NFLAG-1:0] raw_fl, good_fl;
   logic             prot_f, norm_f, swap_f;
   logic             armed, arm_set;
   logic             rec_run, rec_done;
   logic [CNT_W-1:0] rec_cnt;
   guard_state_t     state, state_nx;

   assign rst_all_n = rst_n & fact_rst_n;

   assign raw_fl[FL_PROT] = vdd_above_prot;
   assign raw_fl[FL_NORM] = vdd_above_norm;
   assign raw_fl[FL_SWAP] = vdd_above_swap;

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         pg_flag_cond #(.SYNC_STG(SYNC_STG), .DEB_CYC(DEB_CYC)) u_cond (
            .clk   (clk),
            .rst_n (rst_all_n),
            .raw   (raw_fl[i]),
            .good  (good_fl[i])
         );
      end
   endgenerate

   assign prot_f = good_fl[FL_PROT];
   assign norm_f = good_fl[FL_NORM];
   assign swap_f = good_fl[FL_SWAP];

   assign rec_run = (state == ST_RECOVER) && norm_f;

   pg_rec_timer #(.REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_all_n),
      .run   (rec_run),
      .done  (rec_done),
      .cnt   (rec_cnt)
   );

   assign arm_set = (state == ST_SEALED) && !armed && norm_f && prot_f;

   pg_fresh_latch u_fresh (
      .clk        (clk),
      .fact_rst_n (fact_rst_n),
      .arm        (arm_set),
      .armed      (armed)
   );

   pg_supply_switch u_switch (
      .clk     (clk),
      .rst_n   (rst_all_n),
      .armed   (armed),
      .norm_f  (norm_f),
      .swap_f  (swap_f),
      .bat_sel (bat_sel)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_SEALED: begin
            if (armed)                 state_nx = ST_BATTERY;
            else if (norm_f && prot_f) state_nx = ST_RECOVER;
         end
         ST_BATTERY: begin
            if (norm_f && prot_f)      state_nx = ST_RECOVER;
         end
         ST_RECOVER: begin
            if (!prot_f)               state_nx = ST_BATTERY;
            else if (rec_done)         state_nx = ST_NORMAL;
         end
         ST_NORMAL: begin
            if (!prot_f)               state_nx = ST_BATTERY;
         end
         default:                      state_nx = ST_SEALED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) state <= ST_SEALED;
      else            state <= state_nx;
   end

   assign protect = (state != ST_NORMAL);
   assign ce_n_o  = ce_n_i | protect;
   assign we_n_o  = we_n_i | protect;
   assign oe_n_o  = oe_n_i | protect;
   assign dq_drv  = !protect && !ce_n_i && !oe_n_i && we_n_i;

endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
   parameter int REC_CYC = 25_000_000,
   parameter int CNT_W   = $clog2(REC_CYC)
) (
   input logic             clk,
   input logic             rst_all_n,
   input logic             fact_rst_n,
   input logic             protect,
   input logic             ce_n_o,
   input logic             we_n_o,
   input logic             oe_n_o,
   input logic             dq_drv,
   input logic             bat_sel,
   input logic             armed,
   input logic             prot_f,
   input logic             rec_done,
   input logic [CNT_W-1:0] rec_cnt
);
   AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_all_n)
      protect |-> (ce_n_o && we_n_o && oe_n_o && !dq_drv)); // R2

   AST_FAST_LOCK: assert property (@(posedge clk) disable iff (!rst_all_n)
      $fell(prot_f) |=> protect); // R5

   AST_REC_EXIT: assert property (@(posedge clk) disable iff (!rst_all_n)
      $fell(protect) |-> $past(rec_done)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_all_n)
      rec_cnt <= CNT_W'(REC_CYC - 1)); // R10

   AST_SEAL_NO_BAT: assert property (@(posedge clk) disable iff (!rst_all_n)
      !armed |-> !bat_sel); // R7

   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!fact_rst_n)
      $past(armed) |-> armed); // R11
endmodule

bind pwr_guard pg_guard_chk #(.REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_all_n  (rst_all_n),
   .fact_rst_n (fact_rst_n),
   .protect    (protect),
   .ce_n_o     (ce_n_o),
   .we_n_o     (we_n_o),
   .oe_n_o     (oe_n_o),
   .dq_drv     (dq_drv),
   .bat_sel    (bat_sel),
   .armed      (armed),
   .prot_f     (prot_f),
   .rec_done   (rec_done),
   .rec_cnt    (rec_cnt)
);

// File: tb/tb_pwr_guard.sv
`timescale 1ns/100ps
module tb_pwr_guard;
   localparam int SYNC_STG = 2;
   localparam int DEB_CYC  = 4;
   localparam int REC_CYC  = 50;
   localparam int REL_EDGE = SYNC_STG + DEB_CYC + REC_CYC + 1;

   logic clk = 1'b0;
   logic rst_n, fact_rst_n;
   logic f_prot, f_norm, f_swap;
   logic ce_i, we_i, oe_i;
   logic ce_o, we_o, oe_o, drv, prot, bsel;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pwr_guard #(.SYNC_STG(SYNC_STG), .DEB_CYC(DEB_CYC), .REC_CYC(REC_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .fact_rst_n(fact_rst_n),
      .vdd_above_prot(f_prot), .vdd_above_norm(f_norm), .vdd_above_swap(f_swap),
      .ce_n_i(ce_i), .we_n_i(we_i), .oe_n_i(oe_i),
      .ce_n_o(ce_o), .we_n_o(we_o), .oe_n_o(oe_o),
      .dq_drv(drv), .protect(prot), .bat_sel(bsel)
   );

   function automatic logic [3:0] exp_outs(input logic p, input logic c, input logic w, input logic o);
      logic rd;
      rd = !p && !c && !o && w;
      return {c | p, w | p, o | p, rd};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic rand_strobes(input int n, input logic p_exp, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ce_i = 1'($urandom_range(0, 1));
         we_i = 1'($urandom_range(0, 1));
         oe_i = 1'($urandom_range(0, 1));
         #1;
         chk({ce_o, we_o, oe_o, drv} == exp_outs(p_exp, ce_i, we_i, oe_i), req,
             int'({ce_o, we_o, oe_o, drv}), int'(exp_outs(p_exp, ce_i, we_i, oe_i)));
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; fact_rst_n = 1'b0;
      f_prot = 1'b0; f_norm = 1'b0; f_swap = 1'b0;
      ce_i = 1'b0; we_i = 1'b1; oe_i = 1'b0;
      edges(3);
      @(negedge clk);
      rst_n = 1'b1; fact_rst_n = 1'b1;
      edges(2);
      // R1 reset state
      chk(prot == 1'b1, "R1 protect", prot, 1);
      chk(bsel == 1'b0, "R1 bat_sel", bsel, 0);
      chk({ce_o, we_o, oe_o} == 3'b111, "R1 strobes", int'({ce_o, we_o, oe_o}), 7);
      chk(drv == 1'b0, "R1 dq_drv", drv, 0);

      // R7 sealed: no backup connection before first power-up
      @(negedge clk); f_swap = 1'b1; f_prot = 1'b1;
      edges(15);
      chk(bsel == 1'b0, "R7 sealed swap high", bsel, 0);
      @(negedge clk); f_swap = 1'b0;
      edges(15);
      chk(bsel == 1'b0, "R7 sealed swap low", bsel, 0);

      // R4 first power-up and recovery interval
      @(negedge clk); f_swap = 1'b1; f_prot = 1'b1; f_norm = 1'b1;
      edges(REL_EDGE - 2);
      chk(prot == 1'b1, "R4 still held", prot, 1);
      edges(4);
      chk(prot == 1'b0, "R4 released", prot, 0);

      // R3 random strobes in normal operation
      rand_strobes(120, 1'b0, "R3 pass-through");
      @(negedge clk); ce_i = 1'b0; we_i = 1'b1; oe_i = 1'b0;
      #1;
      chk(drv == 1'b1, "R3 read drives", drv, 1);

      // R6 full-operation flag falls alone; R8 battery connects
      @(negedge clk); f_norm = 1'b0;
      edges(10);
      chk(prot == 1'b0, "R6 hysteresis", prot, 0);
      chk(bsel == 1'b1, "R8 backup on norm fall", bsel, 1);

      // R5 fast protection
      @(negedge clk); f_prot = 1'b0;
      edges(SYNC_STG + 2);
      chk(prot == 1'b1, "R5 protect latency", prot, 1);

      // R2 random strobes while protected
      rand_strobes(40, 1'b1, "R2 gated");

      // R9 switchover hysteresis
      @(negedge clk); f_swap = 1'b0;
      edges(10);
      chk(bsel == 1'b1, "R9 below swap level", bsel, 1);
      @(negedge clk); f_swap = 1'b1;
      edges(10);
      chk(bsel == 1'b0, "R9 above swap level", bsel, 0);
      chk(prot == 1'b1, "R9 still protected", prot, 1);

      // R10 dip during recovery restarts the count
      @(negedge clk); f_prot = 1'b1; f_norm = 1'b1;
      edges(20);
      chk(prot == 1'b1, "R10 in recovery", prot, 1);
      @(negedge clk); f_norm = 1'b0;
      @(negedge clk);
      @(negedge clk); f_norm = 1'b1;
      edges(50);
      chk(prot == 1'b1, "R10 restarted", prot, 1);
      edges(12);
      chk(prot == 1'b0, "R10 released", prot, 0);
      rand_strobes(20, 1'b0, "R3 after recovery");

      // R11 ordinary reset keeps arming
      @(negedge clk); f_prot = 1'b0; f_norm = 1'b0; f_swap = 1'b0;
      edges(10);
      @(negedge clk); rst_n = 1'b0;
      edges(2);
      @(negedge clk); rst_n = 1'b1;
      edges(3);
      chk(bsel == 1'b1, "R11 arming kept", bsel, 1);
      chk(prot == 1'b1, "R11 protected", prot, 1);

      // R12 factory reset clears arming
      @(negedge clk); fact_rst_n = 1'b0;
      edges(2);
      @(negedge clk); fact_rst_n = 1'b1;
      edges(3);
      chk(bsel == 1'b0, "R12 arming cleared", bsel, 0);
      edges(20);
      chk(bsel == 1'b0, "R12 stays sealed", bsel, 0);
      chk(prot == 1'b1, "R12 protected", prot, 1);

      finished = 1;
      summary();
      $finish;
   end
endmodule